// File: doc/BRIEF.md
# Hex Profile Record Parser

This block sits behind a UART receiver and turns a stream of ASCII bytes into profile-memory writes and mode pulses. Two kinds of text line load the profile memory. An address line names a channel (0 or 1) and a four-digit hex address. A record line carries four comma-separated hex fields: frequency, phase, amplitude and dwell. When a well-formed record follows an address line, the block issues one write pulse. The pulse carries the channel, the address and a packed 64-bit word.

Two short mode lines produce single-cycle pulses: one stops the profile and the other toggles it. Letters may be sent in either case. A blank line is skipped. Any byte that breaks the line grammar raises a one-cycle error pulse. The rest of that line is then thrown away without touching the memory.

Top module: `profile_line_parser`

## Requirements
- R1: After synchronous active-low reset every output is low, and no address is armed, so a record line sent right after reset only raises an error.
- R2: An address line is `t` or `T`, then channel digit `0` or `1`, then one or more spaces (0x20), then exactly four hex digits, then CR (0x0D) or LF (0x0A). It arms that channel and address. A value above 0x7FFF, a missing space, a wrong channel digit or a digit count other than four raises an error instead.
- R3: A record line is 8 hex digits, `,` (0x2C), 4 hex digits, `,`, 4 hex digits, `,`, 2 hex digits, then CR or LF, with each field most significant digit first. If an address is armed, `wr_en` is high for exactly one cycle, in the cycle after the terminator byte is accepted. In that cycle `wr_chan` and `wr_addr` carry the armed values. `wr_data` carries frequency in bits 63:32, phase in bits 31:18, amplitude in bits 17:8 and dwell in bits 7:0.
- R4: Only the low 14 bits of the phase field and the low 10 bits of the amplitude field reach `wr_data`. The upper bits of those fields are discarded.
- R5: Hex letters A to F and the command letters `t` and `m` are accepted in upper or lower case with the same result.
- R6: A missing or misplaced comma, a field with too many or too few digits, or any non-hex character inside a record raises an error, and no write occurs.
- R7: Each armed address allows at most one write. A record that completes consumes the arm. A record line while nothing is armed raises an error at its first byte.
- R8: `M` or `m`, then one or more spaces, then `0`, then a terminator gives a one-cycle `stop_pulse`. The same line with `t`/`T` in place of `0` gives a one-cycle `toggle_pulse`. Either pulse comes in the cycle after the terminator, and the line clears any armed address. Any other shape of M line raises an error.
- R9: `err_pulse` rises for one cycle, in the cycle after the first offending byte. Later bytes of the same line raise nothing, and an error clears any armed address. Parsing resumes cleanly after the next terminator.
- R10: An empty line (a lone CR or LF, so CR LF pairs are fine) produces no pulse and keeps an armed address.
- R11: While `in_valid` is low the parser state does not move and no output pulse is produced, whatever `in_byte` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | `in_byte` holds a received character this cycle |
| in_byte | input | 8 | Received ASCII character |
| wr_en | output | 1 | One-cycle profile memory write strobe |
| wr_chan | output | 1 | Channel of the write |
| wr_addr | output | 15 | Profile address of the write |
| wr_data | output | 64 | Packed frequency, phase, amplitude and dwell |
| stop_pulse | output | 1 | One-cycle stop request |
| toggle_pulse | output | 1 | One-cycle run/stop toggle request |
| err_pulse | output | 1 | One-cycle malformed-input indication |

## Verification
Sixty-four generated address/record pairs vary every field value, the channel, the letter case, the spacing and the terminator style. This separates correct field placement and masking from swapped or shifted nibbles. In a full sweep, every byte value except NUL replaces one frequency digit. That sweep shows that exactly the hex digits of either case are accepted, each with its correct nibble value, and every other character is rejected without a write. Targeted lines probe the grammar edges: missing commas, over-long and short fields, the top address and the first out-of-range address, a stray space, a second record under one arm, and mode lines with and without gaps. The byte index of each error shows where it was detected. Idle cycles with changing `in_byte` show that nothing moves without `in_valid`.

// File: rtl/prl_pkg.sv
// Package: prl_pkg
// Shared format constants, parser state type and character class record
// for the hex profile record parser. Assumes the fixed record layout
// of 8/4/4/2 hex digits and a 4-digit address.
package prl_pkg;

    localparam int FREQ_DIGITS  = 8;
    localparam int PHASE_DIGITS = 4;
    localparam int AMP_DIGITS   = 4;
    localparam int DWELL_DIGITS = 2;
    localparam int ADDR_DIGITS  = 4;
    localparam int PHASE_KEEP   = 14;
    localparam int AMP_KEEP     = 10;
    localparam int REC_DIGITS   = FREQ_DIGITS + PHASE_DIGITS + AMP_DIGITS + DWELL_DIGITS;
    localparam int REC_BITS     = 4 * REC_DIGITS;
    localparam int FREQ_BITS    = 4 * FREQ_DIGITS;
    localparam int DWELL_BITS   = 4 * DWELL_DIGITS;
    localparam int WORD_BITS    = FREQ_BITS + PHASE_KEEP + AMP_KEEP + DWELL_BITS;
    // Bit offsets of each field inside the record shift register
    localparam int DWELL_LSB    = 0;
    localparam int AMP_LSB      = DWELL_LSB + 4 * DWELL_DIGITS;
    localparam int PHASE_LSB    = AMP_LSB + 4 * AMP_DIGITS;
    localparam int FREQ_LSB     = PHASE_LSB + 4 * PHASE_DIGITS;

    typedef enum logic [3:0] {
        PS_LINE,    // start of a line
        PS_T_CHAN,  // after 't': channel digit
        PS_T_GAP,   // first mandatory space
        PS_T_SKIP,  // further spaces or first address digit
        PS_T_ADDR,  // address digits
        PS_M_GAP,   // after 'm': first mandatory space
        PS_M_SKIP,  // further spaces or mode argument
        PS_M_END,   // terminator after mode argument
        PS_REC,     // record fields
        PS_DROP     // discarding rest of a bad line
    } prl_state_e;

    typedef struct packed {
        logic       is_hex;
        logic [3:0] nib;
        logic       is_term;
        logic       is_space;
        logic       is_comma;
        logic       is_t;
        logic       is_m;
        logic       is_zero;
        logic       is_one;
    } prl_char_t;

    // Digit count required for record field index f
    function automatic logic [3:0] field_len(input logic [1:0] f);
        case (f)
            2'd0:    return 4'(FREQ_DIGITS);
            2'd1:    return 4'(PHASE_DIGITS);
            2'd2:    return 4'(AMP_DIGITS);
            default: return 4'(DWELL_DIGITS);
        endcase
    endfunction

endpackage

// File: rtl/prl_char_class.sv
// Module: prl_char_class
// Purely combinational classifier of one ASCII byte. Folds upper-case
// letters to lower case and yields the hex nibble value. Assumes 7-bit
// ASCII; bytes above 0x7F fall in no class.
module prl_char_class
    import prl_pkg::*;
(
    input  logic [7:0] ch,
    output prl_char_t  cls
);

    logic [7:0] lc;
    logic       is_dig;
    logic       is_af;

    // Fold case and classify the byte
    always_comb begin
        lc           = (ch >= 8'h41 && ch <= 8'h5A) ? (ch | 8'h20) : ch;
        is_dig       = (lc >= 8'h30) && (lc <= 8'h39);
        is_af        = (lc >= 8'h61) && (lc <= 8'h66);
        cls.is_hex   = is_dig || is_af;
        cls.nib      = is_dig ? lc[3:0] : (lc[3:0] + 4'd9);
        cls.is_term  = (ch == 8'h0D) || (ch == 8'h0A);
        cls.is_space = (ch == 8'h20);
        cls.is_comma = (ch == 8'h2C);
        cls.is_t     = (lc == 8'h74);
        cls.is_m     = (lc == 8'h6D);
        cls.is_zero  = (ch == 8'h30);
        cls.is_one   = (ch == 8'h31);
    end

endmodule

// File: rtl/prl_nibble_shift.sv
// Module: prl_nibble_shift
// Shift register that collects hex nibbles most significant first.
// Holds DIGITS nibbles; older nibbles fall off the top. Assumes the
// controller enforces exact digit counts, so no clear is needed.
module prl_nibble_shift #(
    parameter int DIGITS = 18,
    localparam int W     = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic [3:0]   nib,
    output logic [W-1:0] sr
);

    // Shift one nibble in at the least significant end
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[W-5:0], nib};
    end

endmodule

// File: rtl/prl_line_fsm.sv
// Module: prl_line_fsm
// Line grammar controller. Walks address, record and mode lines one
// byte per accepted cycle. It drives the nibble shifter, keeps the armed
// channel and address, and registers the write, mode and error pulses.
// Assumes the shifter holds every digit of the current line in order.
module prl_line_fsm
    import prl_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  prl_char_t            cls,
    input  logic [REC_BITS-1:0]  sr,
    output logic                 shift_en,
    output logic                 wr_en,
    output logic                 wr_chan,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [WORD_BITS-1:0] wr_data,
    output logic                 stop_pulse,
    output logic                 toggle_pulse,
    output logic                 err_pulse
);

    prl_state_e          state_q, state_d;
    logic [3:0]          cnt_q, cnt_d;
    logic [1:0]          fld_q, fld_d;
    logic                arm_q, arm_d;
    logic                achan_q, achan_d;
    logic [ADDR_W-1:0]   aaddr_q, aaddr_d;
    logic                tch_q, tch_d;
    logic                mtog_q, mtog_d;
    logic                ev_wr, ev_stop, ev_tog, ev_err;
    logic                addr_ok;
    logic [WORD_BITS-1:0] word;
    logic                unused_sr;

    // Address range check and packed data word from the shifter
    assign addr_ok   = ((32'(sr[4*ADDR_DIGITS-1:0]) >> ADDR_W) == 32'd0);
    assign word      = {sr[FREQ_LSB +: FREQ_BITS],
                        sr[PHASE_LSB +: PHASE_KEEP],
                        sr[AMP_LSB +: AMP_KEEP],
                        sr[DWELL_LSB +: DWELL_BITS]};
    assign unused_sr = ^{sr[PHASE_LSB+PHASE_KEEP +: 4*PHASE_DIGITS-PHASE_KEEP],
                         sr[AMP_LSB+AMP_KEEP +: 4*AMP_DIGITS-AMP_KEEP]};

    // Next-state and event decode for one accepted byte
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        fld_d    = fld_q;
        arm_d    = arm_q;
        achan_d  = achan_q;
        aaddr_d  = aaddr_q;
        tch_d    = tch_q;
        mtog_d   = mtog_q;
        shift_en = 1'b0;
        ev_wr    = 1'b0;
        ev_stop  = 1'b0;
        ev_tog   = 1'b0;
        ev_err   = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                PS_LINE: begin
                    if (cls.is_term) begin
                        state_d = PS_LINE;
                    end else if (cls.is_t) begin
                        state_d = PS_T_CHAN;
                    end else if (cls.is_m) begin
                        state_d = PS_M_GAP;
                    end else if (cls.is_hex && arm_q) begin
                        shift_en = 1'b1;
                        cnt_d    = 4'd1;
                        fld_d    = 2'd0;
                        state_d  = PS_REC;
                    end else begin
                        ev_err = 1'b1;
                    end
                end
                PS_T_CHAN: begin
                    if (cls.is_zero || cls.is_one) begin
                        tch_d   = cls.is_one;
                        state_d = PS_T_GAP;
                    end else begin
                        ev_err = 1'b1;
                    end
                end
                PS_T_GAP: begin
                    if (cls.is_space) state_d = PS_T_SKIP;
                    else              ev_err  = 1'b1;
                end
                PS_T_SKIP: begin
                    if (cls.is_space) begin
                        state_d = PS_T_SKIP;
                    end else if (cls.is_hex) begin
                        shift_en = 1'b1;
                        cnt_d    = 4'd1;
                        state_d  = PS_T_ADDR;
                    end else begin
                        ev_err = 1'b1;
                    end
                end
                PS_T_ADDR: begin
                    if (cls.is_hex && cnt_q != 4'(ADDR_DIGITS)) begin
                        shift_en = 1'b1;
                        cnt_d    = cnt_q + 4'd1;
                    end else if (cls.is_term && cnt_q == 4'(ADDR_DIGITS) && addr_ok) begin
                        arm_d   = 1'b1;
                        achan_d = tch_q;
                        aaddr_d = sr[ADDR_W-1:0];
                        state_d = PS_LINE;
                    end else begin
                        ev_err = 1'b1;
                    end
                end
                PS_M_GAP: begin
                    if (cls.is_space) state_d = PS_M_SKIP;
                    else              ev_err  = 1'b1;
                end
                PS_M_SKIP: begin
                    if (cls.is_space) begin
                        state_d = PS_M_SKIP;
                    end else if (cls.is_zero) begin
                        mtog_d  = 1'b0;
                        state_d = PS_M_END;
                    end else if (cls.is_t) begin
                        mtog_d  = 1'b1;
                        state_d = PS_M_END;
                    end else begin
                        ev_err = 1'b1;
                    end
                end
                PS_M_END: begin
                    if (cls.is_term) begin
                        ev_stop = !mtog_q;
                        ev_tog  = mtog_q;
                        arm_d   = 1'b0;
                        state_d = PS_LINE;
                    end else begin
                        ev_err = 1'b1;
                    end
                end
                PS_REC: begin
                    if (cls.is_hex && cnt_q != field_len(fld_q)) begin
                        shift_en = 1'b1;
                        cnt_d    = cnt_q + 4'd1;
                    end else if (cls.is_comma && fld_q != 2'd3 && cnt_q == field_len(fld_q)) begin
                        fld_d = fld_q + 2'd1;
                        cnt_d = 4'd0;
                    end else if (cls.is_term && fld_q == 2'd3 && cnt_q == field_len(fld_q)) begin
                        ev_wr   = 1'b1;
                        arm_d   = 1'b0;
                        state_d = PS_LINE;
                    end else begin
                        ev_err = 1'b1;
                    end
                end
                PS_DROP: begin
                    if (cls.is_term) state_d = PS_LINE;
                end
                default: state_d = PS_LINE;
            endcase
            if (ev_err) begin
                arm_d   = 1'b0;
                state_d = cls.is_term ? PS_LINE : PS_DROP;
            end
        end
    end

    // Parser state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_LINE;
            cnt_q   <= '0;
            fld_q   <= '0;
            arm_q   <= 1'b0;
            achan_q <= 1'b0;
            aaddr_q <= '0;
            tch_q   <= 1'b0;
            mtog_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            fld_q   <= fld_d;
            arm_q   <= arm_d;
            achan_q <= achan_d;
            aaddr_q <= aaddr_d;
            tch_q   <= tch_d;
            mtog_q  <= mtog_d;
        end
    end

    // Registered output pulses and write payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en        <= 1'b0;
            wr_chan      <= 1'b0;
            wr_addr      <= '0;
            wr_data      <= '0;
            stop_pulse   <= 1'b0;
            toggle_pulse <= 1'b0;
            err_pulse    <= 1'b0;
        end else begin
            wr_en        <= ev_wr;
            stop_pulse   <= ev_stop;
            toggle_pulse <= ev_tog;
            err_pulse    <= ev_err;
            if (ev_wr) begin
                wr_chan <= achan_q;
                wr_addr <= aaddr_q;
                wr_data <= word;
            end
        end
    end

    // R7: a completed write has consumed the arm
    a_r7_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !arm_q);

    // R7: record parsing only runs under an armed address
    a_r7_rec_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_REC) |-> arm_q);

    // R9: at most one kind of pulse per accepted byte
    a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, stop_pulse, toggle_pulse, err_pulse}));

    // R9: discarding a line raises nothing further
    a_r9_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DROP) |=> !err_pulse && !wr_en);

    // R11: no movement and no pulse without in_valid
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(state_q) && !(wr_en || stop_pulse || toggle_pulse || err_pulse));

    // R6: digit counter never exceeds the widest field
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_REC) |-> (cnt_q <= 4'(FREQ_DIGITS)));

endmodule

// File: rtl/profile_line_parser.sv
// Module: profile_line_parser
// Top of the hex profile record parser: classifier, nibble shifter and
// line controller. Takes one byte per cycle when in_valid is high and
// gives registered write, stop, toggle and error pulses. Assumes bytes
// come from a UART receiver with no back-pressure.
module profile_line_parser
    import prl_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    output logic                 wr_en,
    output logic                 wr_chan,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [WORD_BITS-1:0] wr_data,
    output logic                 stop_pulse,
    output logic                 toggle_pulse,
    output logic                 err_pulse
);

    prl_char_t           cls;
    logic                shift_en;
    logic [REC_BITS-1:0] sr;

    prl_char_class u_class (
        .ch  (in_byte),
        .cls (cls)
    );

    prl_nibble_shift #(.DIGITS(REC_DIGITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .nib      (cls.nib),
        .sr       (sr)
    );

    prl_line_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .cls          (cls),
        .sr           (sr),
        .shift_en     (shift_en),
        .wr_en        (wr_en),
        .wr_chan      (wr_chan),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .stop_pulse   (stop_pulse),
        .toggle_pulse (toggle_pulse),
        .err_pulse    (err_pulse)
    );

endmodule

// File: tb/tb_profile_line_parser.sv
module tb_profile_line_parser;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        wr_en, wr_chan, stop_pulse, toggle_pulse, err_pulse;
    logic [14:0] wr_addr;
    logic [63:0] wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // per-line observation
    int          l_wr, l_stop, l_tog, l_err, l_err_at, l_wr_at, l_ev_at, b_idx;
    logic        l_chan;
    logic [14:0] l_addr;
    logic [63:0] l_data;
    logic [31:0] seed = 32'h1234_abcd;

    profile_line_parser dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr), .wr_data(wr_data),
        .stop_pulse(stop_pulse), .toggle_pulse(toggle_pulse), .err_pulse(err_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clr();
        l_wr = 0; l_stop = 0; l_tog = 0; l_err = 0;
        l_err_at = -1; l_wr_at = -1; l_ev_at = -1; b_idx = 0;
    endtask

    // drive one byte at a negedge, observe the registered result one cycle later
    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        if (wr_en) begin
            l_wr++; l_wr_at = b_idx; l_chan = wr_chan; l_addr = wr_addr; l_data = wr_data;
        end
        if (stop_pulse)   begin l_stop++; l_ev_at = b_idx; end
        if (toggle_pulse) begin l_tog++;  l_ev_at = b_idx; end
        if (err_pulse) begin
            l_err++;
            if (l_err_at < 0) l_err_at = b_idx;
        end
        b_idx++;
        in_valid = 1'b0;
    endtask

    task automatic send(input string s);
        for (int i = 0; i < s.len(); i++) put(s[i]);
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    // bench's own hex value of a character, -1 if not hex
    function automatic int hexval(input logic [7:0] c);
        if (c >= "0" && c <= "9") return int'(c) - 48;
        if (c >= "a" && c <= "f") return int'(c) - 87;
        if (c >= "A" && c <= "F") return int'(c) - 55;
        return -1;
    endfunction

    function automatic logic [63:0] pack(input logic [31:0] f, input logic [15:0] p,
                                         input logic [15:0] a, input logic [7:0] d);
        return {f, p[13:0], a[9:0], d};
    endfunction

    function automatic string mkrec(input logic [31:0] f, input logic [15:0] p,
                                    input logic [15:0] a, input logic [7:0] d, input bit up);
        string s;
        s = $sformatf("%08h,%04h,%04h,%02h", f, p, a, d);
        return up ? s.toupper() : s;
    endfunction

    task automatic arm(input bit ch, input logic [14:0] ad);
        clr();
        send($sformatf("t%0d %04h\n", ch, ad));
        chk(l_err == 0 && l_wr == 0, "R2", "arm line quiet", 64'(l_err), 0);
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] f;
        logic [15:0] p, a;
        logic [7:0]  d;
        logic [14:0] ad;
        string       s;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk({wr_en, stop_pulse, toggle_pulse, err_pulse} == 4'b0, "R1", "pulses after reset",
            64'({wr_en, stop_pulse, toggle_pulse, err_pulse}), 0);
        chk(wr_data == 0 && wr_addr == 0, "R1", "write payload after reset", wr_data, 0);
        clr(); send("00000000,0000,0000,01\n");
        chk(l_err == 1 && l_err_at == 0 && l_wr == 0, "R1", "record unarmed after reset", 64'(l_err_at), 0);

        // R3 R4 R5 R2 R10: generated sweep of fields, case, spacing, terminators
        for (int k = 0; k < 64; k++) begin
            f = rnd(); p = rnd()[15:0]; a = rnd()[15:0]; d = rnd()[7:0]; ad = rnd()[14:0];
            if (k == 0) ad = 15'h0000;
            if (k == 1) ad = 15'h7fff;
            clr();
            s = $sformatf("%s%0d%s%04h%s", k[1] ? "T" : "t", k[0], k[2] ? "   " : " ", ad,
                          k[3] ? "\r" : "\n");
            send(k[1] ? s.toupper() : s);
            chk(l_err == 0 && l_wr == 0, "R2", "address line accepted", 64'(l_err), 0);
            if (k[4]) begin
                clr(); send("\r\n");
                chk(l_err == 0 && l_wr == 0, "R10", "empty lines silent", 64'(l_err), 0);
            end
            clr(); send({mkrec(f, p, a, d, k[1]), k[4] ? "\r\n" : "\n"});
            chk(l_wr == 1 && l_err == 0, "R3", "one write", 64'(l_wr), 1);
            chk(l_wr_at == 21, "R3", "write one cycle after terminator", 64'(l_wr_at), 21);
            chk(l_chan == k[0] && l_addr == ad, "R2", "channel/address", {l_chan, l_addr}, {k[0], ad});
            chk(l_data == pack(f, p, a, d), "R4", "packed word", l_data, pack(f, p, a, d));
        end

        // R5 R6: sweep every byte value into frequency digit 4
        for (int c = 1; c < 256; c++) begin
            arm(1'b1, 15'h0123);
            s = "12345678,9abc,def0,5a\n";
            s.putc(4, byte'(c));
            clr(); send(s);
            if (hexval(8'(c)) >= 0) begin
                f = {16'h1234, 4'(hexval(8'(c))), 12'h678};
                chk(l_wr == 1 && l_err == 0 && l_data == pack(f, 16'h9abc, 16'hdef0, 8'h5a),
                    "R5", $sformatf("hex char %0h", c), l_data, pack(f, 16'h9abc, 16'hdef0, 8'h5a));
            end else begin
                chk(l_wr == 0 && l_err >= 1, "R6", $sformatf("non-hex char %0h", c), 64'(l_wr), 0);
            end
        end

        // R6: punctuation and digit counts
        arm(0, 15'h10); clr(); send("12345678;9abc,def0,5a\n");
        chk(l_wr == 0 && l_err == 1 && l_err_at == 8, "R6", "missing comma", 64'(l_err_at), 8);
        arm(0, 15'h10); clr(); send("123456789,9abc,def0,5a\n");
        chk(l_wr == 0 && l_err == 1 && l_err_at == 8, "R6", "ninth freq digit", 64'(l_err_at), 8);
        arm(0, 15'h10); clr(); send("12345678,9abc,def0,5\n");
        chk(l_wr == 0 && l_err == 1 && l_err_at == 20, "R6", "short dwell", 64'(l_err_at), 20);
        arm(0, 15'h10); clr(); send("12345678,9abc,def0\n");
        chk(l_wr == 0 && l_err == 1 && l_err_at == 18, "R6", "missing dwell", 64'(l_err_at), 18);
        arm(0, 15'h10); clr(); send("12345678,9abc,,def0,5a\n");
        chk(l_wr == 0 && l_err == 1 && l_err_at == 14, "R6", "double comma", 64'(l_err_at), 14);

        // R7: one write per arm
        arm(1, 15'h55); clr(); send("00000001,0000,0000,01\n");
        chk(l_wr == 1, "R7", "first record writes", 64'(l_wr), 1);
        clr(); send("00000002,0000,0000,01\n");
        chk(l_wr == 0 && l_err == 1 && l_err_at == 0, "R7", "second record rejected", 64'(l_err_at), 0);

        // R2: address line edges
        clr(); send("t0 8000\n");
        chk(l_err == 1 && l_err_at == 7, "R2", "address 0x8000 rejected", 64'(l_err_at), 7);
        clr(); send("00000001,0000,0000,01\n");
        chk(l_wr == 0 && l_err == 1, "R2", "no arm after bad address", 64'(l_wr), 0);
        clr(); send("t2 0000\n");
        chk(l_err == 1 && l_err_at == 1, "R2", "bad channel digit", 64'(l_err_at), 1);
        clr(); send("t00000\n");
        chk(l_err == 1 && l_err_at == 2, "R2", "missing space", 64'(l_err_at), 2);
        clr(); send("t1 012\n");
        chk(l_err == 1 && l_err_at == 6, "R2", "three address digits", 64'(l_err_at), 6);
        clr(); send("t1 01234\n");
        chk(l_err == 1 && l_err_at == 7, "R2", "five address digits", 64'(l_err_at), 7);

        // R8: mode lines
        clr(); send("M 0\n");
        chk(l_stop == 1 && l_tog == 0 && l_err == 0 && l_ev_at == 3, "R8", "stop pulse", 64'(l_ev_at), 3);
        clr(); send("m    T\r");
        chk(l_tog == 1 && l_stop == 0 && l_err == 0 && l_ev_at == 6, "R8", "toggle pulse", 64'(l_ev_at), 6);
        clr(); send("M t\n");
        chk(l_tog == 1 && l_err == 0, "R5", "toggle lower case t", 64'(l_tog), 1);
        clr(); send("M0\n");
        chk(l_err == 1 && l_err_at == 1 && l_stop == 0, "R8", "no gap rejected", 64'(l_err_at), 1);
        clr(); send("M 1\n");
        chk(l_err == 1 && l_err_at == 2, "R8", "bad mode argument", 64'(l_err_at), 2);
        clr(); send("M 0 \n");
        chk(l_err == 1 && l_err_at == 3 && l_stop == 0, "R8", "trailing space", 64'(l_err_at), 3);
        arm(0, 15'h20); clr(); send("M t\n"); send("00000001,0000,0000,01\n");
        chk(l_wr == 0 && l_err == 1, "R8", "mode line clears arm", 64'(l_wr), 0);

        // R9: error timing, discard and recovery
        clr(); send("xyz,12 M 0\n");
        chk(l_err == 1 && l_err_at == 0 && l_stop == 0, "R9", "single error then discard", 64'(l_err), 1);
        clr(); send("M 0\n");
        chk(l_stop == 1 && l_err == 0, "R9", "recovery after discard", 64'(l_stop), 1);
        arm(1, 15'h33); clr(); send("q\n"); send("00000001,0000,0000,01\n");
        chk(l_wr == 0 && l_err == 2, "R9", "error clears arm", 64'(l_err), 2);

        // R10: arm kept across empty lines
        arm(1, 15'h44); clr(); send("\r\n\n\r");
        chk(l_err == 0, "R10", "empty lines", 64'(l_err), 0);
        clr(); send("0000abcd,ffff,ffff,ff\n");
        chk(l_wr == 1 && l_addr == 15'h44 && l_data == pack(32'h0000abcd, 16'hffff, 16'hffff, 8'hff),
            "R10", "write after empty lines", l_data, pack(32'h0000abcd, 16'hffff, 16'hffff, 8'hff));

        // R11: bytes ignored without in_valid
        arm(0, 15'h66);
        begin
            int quiet = 1;
            for (int i = 0; i < 24; i++) begin
                in_valid = 1'b0;
                in_byte  = (i % 3 == 0) ? 8'h0A : ((i % 3 == 1) ? "M" : "z");
                @(negedge clk);
                if (wr_en || stop_pulse || toggle_pulse || err_pulse) quiet = 0;
            end
            chk(quiet == 1, "R11", "no pulse while idle", 64'(quiet), 1);
        end
        clr(); send("11223344,5566,7788,99\n");
        chk(l_wr == 1 && l_addr == 15'h66 && l_data == pack(32'h11223344, 16'h5566, 16'h7788, 8'h99),
            "R11", "arm survives idle bytes", l_data, pack(32'h11223344, 16'h5566, 16'h7788, 8'h99));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule